// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This block is a register-mapped timer with a parameterised number of independent channels. Each channel owns a 64-bit down counter, a 64-bit interval, a 3-bit prescaler, and a run-mode choice between periodic and single-shot. The counter moves only on a timer tick input, which is a clock enable. When a channel counts past zero it raises its pending flag. An enable mask gates the pending flags, and the gated flags are combined into one interrupt line.

Software reaches the block through a flat register port with a combinational read path and a single-cycle write strobe. A channel is armed by one control write that sets both enable and reload. That write copies the interval into the counter. A periodic channel with the largest interval runs as a free-running counter, and the inverse of its count serves as a rising timestamp. A stop request does not take hold at once: the channel keeps counting for two more ticks.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: Interrupt enable is read and written at 0x00, with bit n belonging to channel n. Channel n places control at 0x10+0x20n, interval low at 0x14+0x20n, interval high at 0x18+0x20n, count low at 0x1C+0x20n and count high at 0x20+0x20n. Interval words read back as written. Unmapped addresses read 0.
- R3: A control write with bit 1 (reload) set loads the interval into the counter at that clock edge. Reload always reads back as 0. Control reads back with bit 0 as enable, bits 6:4 as prescaler and bit 7 as one-shot.
- R4: With prescaler p, an enabled channel counts one step for every 2^p ticks after its load. After T ticks it has taken floor(T/2^p) steps. With no tick, the count holds.
- R5: A step taken while the count is 0 sets the channel's pending bit. In periodic mode (bit 7 clear), the same step reloads the interval, so an interval I gives a period of I+1 steps.
- R6: In one-shot mode (bit 7 set), the expiring step sets pending, clears the enable bit and leaves the count held at 0.
- R7: A control write that clears enable on a running channel lets the channel count for exactly two more ticks, after which it stops.
- R8: The pending bits read at 0x04. Writing 1 to bit n there clears channel n's flag, and bits written as 0 are unchanged. If an expiry and a clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when some channel has both its pending bit and its enable bit set.
- R10: The count borrows across its 32-bit halves. A periodic channel loaded with an all-ones interval counts freely, and the inverse of its count equals the number of steps taken.
- R11: Channels count independently: stopping, loading or expiring one channel does not change another channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 32 | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume two things about the inputs. First, each write is a single-cycle strobe at an aligned address. Second, a reload write never arrives in the same cycle as a tick, because the load takes priority over counting and the count checks depend on that order. The stimulus holds `tick` low around every register access and pulses it only between accesses, so every count can be predicted from the tick total and the prescaler. The prescaler sweep covers all eight divider settings, checking each one just before a step boundary and just after it.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int PRE_W = 3;

  typedef struct packed {
    logic             load;
    logic             enable;
    logic             stopReq;
    logic             oneshot;
    logic [PRE_W-1:0] pre;
  } chanCmd_t;
endpackage

// File: rtl/evt_chan.sv
module evt_chan
  import evt_pkg::*;
#(
  parameter int CNT_W      = 64,
  parameter int HOLD_TICKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  chanCmd_t         cmd,
  input  logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int DIV_W = (2 ** PRE_W) - 1;
  localparam int KA_W  = $clog2(HOLD_TICKS + 1);

  logic [CNT_W-1:0] countQ;
  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] divMask;
  logic [KA_W-1:0]  keepQ;
  logic             active;
  logic             step;

  assign active  = cmd.enable || (keepQ != '0);
  assign divMask = (DIV_W'(1) << cmd.pre) - DIV_W'(1);
  assign step    = tick && active && ((divQ & divMask) == divMask) && !cmd.load;
  assign expire  = step && (countQ == '0);
  assign count   = countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      divQ   <= '0;
      keepQ  <= '0;
    end else if (cmd.load) begin
      countQ <= interval;
      divQ   <= '0;
      keepQ  <= '0;
    end else begin
      if (tick && active) divQ <= divQ + DIV_W'(1);
      if (step) begin
        if (countQ != '0)     countQ <= countQ - CNT_W'(1);
        else if (cmd.oneshot) countQ <= '0;
        else                  countQ <= interval;
      end
      if (cmd.stopReq)                keepQ <= KA_W'(HOLD_TICKS);
      else if (expire && cmd.oneshot) keepQ <= '0;
      else if (tick && keepQ != '0)   keepQ <= keepQ - KA_W'(1);
    end
  end

  // R4: without a tick or a load the count does not move
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !tick) |=> $stable(countQ));
  // R3: a reload strobe leaves the interval in the counter
  a_r3_load_value: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (countQ == $past(interval)));
  // R7: the stop window never exceeds its fixed length
  a_r7_keep_bound: assert property (@(posedge clk) disable iff (!rstN)
    keepQ <= KA_W'(HOLD_TICKS));
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           wr,
  output logic [DATA_W-1:0]              rdata,
  input  logic [NUM_CH-1:0]              expire,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   count,
  output chanCmd_t [NUM_CH-1:0]          cmd,
  output logic [NUM_CH-1:0][CNT_W-1:0]   interval,
  output logic                           irq
);
  localparam int HI_W     = CNT_W - DATA_W;
  localparam int CH_SEL_W = ADDR_W - 5;

  logic [NUM_CH-1:0]            irqEnQ, pendQ, enQ, oneQ;
  logic [NUM_CH-1:0][PRE_W-1:0] preQ;
  logic [NUM_CH-1:0][CNT_W-1:0] ivQ;

  logic [ADDR_W-1:0]   offs;
  logic [CH_SEL_W-1:0] chSel;
  logic [2:0]          regSel;
  logic                isChan, wrEn, wrStat;
  logic [NUM_CH-1:0]   chHit, wrCtrl, wrIvLo, wrIvHi;

  assign offs   = addr - ADDR_W'(16);
  assign chSel  = offs[ADDR_W-1:5];
  assign regSel = offs[4:2];
  assign isChan = (addr >= ADDR_W'(16)) && (offs[1:0] == 2'b00);
  assign wrEn   = wr && (addr == ADDR_W'(0));
  assign wrStat = wr && (addr == ADDR_W'(4));

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      chHit[i]  = isChan && (chSel == CH_SEL_W'(i));
      wrCtrl[i] = wr && chHit[i] && (regSel == 3'd0);
      wrIvLo[i] = wr && chHit[i] && (regSel == 3'd1);
      wrIvHi[i] = wr && chHit[i] && (regSel == 3'd2);
      cmd[i].load    = wrCtrl[i] && wdata[1];
      cmd[i].enable  = enQ[i];
      cmd[i].stopReq = wrCtrl[i] && enQ[i] && !wdata[0];
      cmd[i].oneshot = oneQ[i];
      cmd[i].pre     = preQ[i];
    end
  end

  assign interval = ivQ;
  assign irq      = |(pendQ & irqEnQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnQ <= '0;
      pendQ  <= '0;
      enQ    <= '0;
      oneQ   <= '0;
      preQ   <= '0;
      ivQ    <= '0;
    end else begin
      if (wrEn) irqEnQ <= wdata[NUM_CH-1:0];
      pendQ <= (pendQ & ~(wrStat ? wdata[NUM_CH-1:0] : '0)) | expire;
      for (int i = 0; i < NUM_CH; i++) begin
        if (wrCtrl[i]) begin
          enQ[i]  <= wdata[0];
          oneQ[i] <= wdata[7];
          preQ[i] <= wdata[6:4];
        end else if (expire[i] && oneQ[i]) begin
          enQ[i] <= 1'b0;
        end
        if (wrIvLo[i]) ivQ[i][DATA_W-1:0]     <= wdata;
        if (wrIvHi[i]) ivQ[i][CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(0))      rdata = DATA_W'(irqEnQ);
    else if (addr == ADDR_W'(4)) rdata = DATA_W'(pendQ);
    else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (chHit[i]) begin
          case (regSel)
            3'd0: rdata = {24'b0, oneQ[i], preQ[i], 3'b000, enQ[i]};
            3'd1: rdata = ivQ[i][DATA_W-1:0];
            3'd2: rdata = DATA_W'(ivQ[i][CNT_W-1:DATA_W]);
            3'd3: rdata = count[i][DATA_W-1:0];
            3'd4: rdata = DATA_W'(count[i][CNT_W-1:DATA_W]);
            default: rdata = '0;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    // R5: an expiry always leaves the flag raised
    a_r5_pend_set: assert property (@(posedge clk) disable iff (!rstN)
      expire[g] |=> pendQ[g]);
    // R8: writing one clears a flag when no expiry competes
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rstN)
      (wrStat && wdata[g] && !expire[g]) |=> !pendQ[g]);
    // R8: a flag changes only through expiry or a write of one
    a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!expire[g] && !(wrStat && wdata[g])) |=> $stable(pendQ[g]));
    // R6: single-shot expiry drops the enable bit
    a_r6_oneshot_off: assert property (@(posedge clk) disable iff (!rstN)
      (expire[g] && oneQ[g] && !wrCtrl[g]) |=> !enQ[g]);
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int CNT_W      = 64,
  parameter int ADDR_W     = 8,
  parameter int HOLD_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wr,
  output logic [31:0]       rdata,
  output logic              irq
);
  chanCmd_t [NUM_CH-1:0]        cmd;
  logic [NUM_CH-1:0][CNT_W-1:0] interval;
  logic [NUM_CH-1:0][CNT_W-1:0] count;
  logic [NUM_CH-1:0]            expire;

  evt_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(32)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .wr(wr), .rdata(rdata),
    .expire(expire), .count(count), .cmd(cmd), .interval(interval), .irq(irq)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    evt_chan #(.CNT_W(CNT_W), .HOLD_TICKS(HOLD_TICKS)) uChan (
      .clk(clk), .rstN(rstN), .tick(tick), .cmd(cmd[g]),
      .interval(interval[g]), .count(count[g]), .expire(expire[g])
    );
  end
endmodule

// File: tb/evt_timer_test.sv
`timescale 1ns/100ps
module evt_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  evt_timer uut (.clk(clk), .rstN(rstN), .tick(tick), .addr(addr),
                 .wdata(wdata), .wr(wr), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rdCnt(input int ch, output logic [63:0] c);
    logic [31:0] lo, hi;
    rdReg(8'(8'h1C + 32 * ch), lo);
    rdReg(8'(8'h20 + 32 * ch), hi);
    c = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic setIv(input int ch, input logic [63:0] v);
    wrReg(8'(8'h14 + 32 * ch), v[31:0]);
    wrReg(8'(8'h18 + 32 * ch), v[63:32]);
  endtask

  initial begin
    logic [31:0] v;
    logic [63:0] c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdReg(8'h00, v); chk("R1 irq enable", v, 0);
    rdReg(8'h04, v); chk("R1 status", v, 0);
    rdReg(8'h10, v); chk("R1 ctrl0", v, 0);
    rdReg(8'h34, v); chk("R1 interval1", v, 0);
    rdCnt(0, c);     chk("R1 count0", c, 0);
    chk("R1 irq", irq, 0);
    // R2 map and readback
    wrReg(8'h14, 32'h11223344); wrReg(8'h18, 32'h55667788);
    rdReg(8'h14, v); chk("R2 iv lo", v, 32'h11223344);
    rdReg(8'h18, v); chk("R2 iv hi", v, 32'h55667788);
    wrReg(8'h34, 32'h0000AAAA);
    rdReg(8'h34, v); chk("R2 iv1 lo", v, 32'h0000AAAA);
    wrReg(8'h00, 32'h3); rdReg(8'h00, v); chk("R2 irq enable", v, 3);
    wrReg(8'h00, 32'h0);
    rdReg(8'h0C, v); chk("R2 unmapped", v, 0);
    // R3 load
    setIv(0, 64'd5);
    wrReg(8'h10, 32'h3);
    rdCnt(0, c); chk("R3 loaded", c, 5);
    rdReg(8'h10, v); chk("R3 ctrl reload reads 0", v, 32'h1);
    // R4 counting
    ticks(3); rdCnt(0, c); chk("R4 after 3", c, 2);
    // R5 periodic expiry
    ticks(2); rdCnt(0, c); chk("R5 at zero", c, 0);
    rdReg(8'h04, v); chk("R5 not yet pending", v, 0);
    ticks(1); rdReg(8'h04, v); chk("R5 pending", v, 1);
    rdCnt(0, c); chk("R5 reloaded", c, 5);
    // R9 masking
    chk("R9 masked", irq, 0);
    wrReg(8'h00, 32'h1); #1 chk("R9 unmasked", irq, 1);
    // R8 write-one-to-clear
    wrReg(8'h04, 32'h2); rdReg(8'h04, v); chk("R8 other bit", v, 1);
    wrReg(8'h04, 32'h1); rdReg(8'h04, v); chk("R8 cleared", v, 0);
    chk("R9 irq low", irq, 0);
    // R7 stop latency
    wrReg(8'h10, 32'h0);
    ticks(5); rdCnt(0, c); chk("R7 two more", c, 3);
    rdReg(8'h10, v); chk("R7 ctrl off", v, 0);
    // R6 one-shot on channel 1
    setIv(1, 64'd2);
    wrReg(8'h30, 32'h83);
    ticks(3); rdReg(8'h04, v); chk("R6 pending", v, 2);
    rdReg(8'h30, v); chk("R6 enable cleared", v, 32'h80);
    ticks(4); rdCnt(1, c); chk("R6 held", c, 0);
    rdCnt(0, c); chk("R11 ch0 untouched", c, 3);
    // R9 OR over channels
    chk("R9 ch1 masked", irq, 0);
    wrReg(8'h00, 32'h2); #1 chk("R9 ch1 irq", irq, 1);
    wrReg(8'h04, 32'h3); #1 chk("R9 cleared", irq, 0);
    // R4 prescaler sweep
    for (int p = 0; p < 8; p++) begin
      setIv(0, 64'd100);
      wrReg(8'h10, 32'((p << 4) | 3));
      ticks(3 * (1 << p) - 1); rdCnt(0, c); chk("R4 before step", c, 98);
      ticks(1); rdCnt(0, c); chk("R4 at step", c, 97);
    end
    rdCnt(1, c); chk("R11 ch1 held", c, 0);
    // R10 borrow and free-running
    setIv(0, 64'h1_0000_0000);
    wrReg(8'h10, 32'h3);
    ticks(1); rdCnt(0, c); chk("R10 borrow", c, 64'h0000_0000_FFFF_FFFF);
    setIv(0, '1);
    wrReg(8'h10, 32'h3);
    ticks(7); rdCnt(0, c); chk("R10 timestamp", ~c, 7);
    // R5 zero interval expires every step
    wrReg(8'h04, 32'h3);
    setIv(0, 64'd0);
    wrReg(8'h10, 32'h3);
    ticks(1); rdReg(8'h04, v); chk("R5 zero interval", v, 1);
    rdCnt(0, c); chk("R5 zero reload", c, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule